// File: doc/BRIEF.md
# Serial Link Input Frame Receiver

This block sits on the controller side of a codec serial link. It takes in the codec's input-frame line and turns it back into words. The codec launches each bit on the rising edge of the serial clock. The receiver samples every bit on the falling edge that follows. A frame begins when the frame strobe is seen going from low to high. The bits that follow make up a 16-bit tag and then twelve 20-bit slots, 256 bits in all, each field sent most significant bit first.

From each frame the receiver takes the link-ready flag, a status-read reply (a register index and its data) and the left and right capture samples. Each result comes out with a single-cycle valid strobe. A strobe fires only when the matching tag bits mark that slot as valid. A frame whose ready bit is clear yields no strobes at all. All logic runs on the serial clock.

The outputs are valid-only streams and have no ready input. The serial line cannot be stalled, so there is no back-pressure. A consumer must take each word in the one cycle its strobe is high. The data outputs keep their last value between strobes.

Top module: `ac_rx_deser`

## Requirements
- R1: The receiver samples `frm_sync` and `ser_in` on falling `ser_clk` edges. A frame starts on the falling edge where `frm_sync` is 1 and was 0 on the previous falling edge. The next falling edge samples frame bit 0, which is tag bit 15. `frm_sync` is treated as 1 before the first edge after reset, so a strobe that is already high at reset release starts no frame.
- R2: A frame is 256 bits: tag bits 15..0, then slots 1 to 12 of 20 bits each, MSB first. Frame bit k is sampled on the (k+1)-th falling edge after the start edge. `frame_done` is high for exactly one clock period, starting at the falling edge that samples bit 255. Every strobe output is high for exactly one clock period.
- R3: `link_ready` takes the value of tag bit 15 at the falling edge that samples frame bit 15. It keeps that value until the next tag arrives.
- R4: When tag bit 15 is 0, no status, left or right strobe fires for that frame, whatever the other tag bits and slots contain. `frame_done` still pulses.
- R5: `stat_valid` fires only when tag bits 15, 14 and 13 are all 1. It starts at the edge that samples frame bit 55, the last bit of slot 2. `stat_index` is slot 1 bits 18:12 and `stat_data` is slot 2 bits 19:4.
- R6: `left_valid` fires only when tag bits 15 and 12 are set. It starts at the edge that samples frame bit 75, the last bit of slot 3, and `left_sample` carries all 20 bits of slot 3.
- R7: `right_valid` fires only when tag bits 15 and 11 are set. It starts at the edge that samples frame bit 95, the last bit of slot 4, and `right_sample` carries all 20 bits of slot 4.
- R8: A frame start seen before bit 255 is sampled cancels the current frame. That frame then gets no `frame_done` and no strobe for any slot not yet complete. Reception restarts at bit 0.
- R9: A frame start can be seen on the same edge that samples bit 255. That frame then completes normally with `frame_done`, and the next frame's bit 0 is sampled on the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ser_clk | input | 1 | Serial bit clock; all logic acts on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_sync | input | 1 | Frame strobe from the link |
| ser_in | input | 1 | Serial input-frame data |
| link_ready | output | 1 | Codec-ready bit of the latest tag |
| stat_valid | output | 1 | One-cycle strobe for a status reply |
| stat_index | output | 7 | Register index of the status reply |
| stat_data | output | 16 | Data of the status reply |
| left_valid | output | 1 | One-cycle strobe for a left sample |
| left_sample | output | 20 | Left capture sample |
| right_valid | output | 1 | One-cycle strobe for a right sample |
| right_sample | output | 20 | Right capture sample |
| frame_done | output | 1 | One-cycle pulse when a full frame is received |

## Verification
A bit position counter that is off by one shows within the first frame. Every strobe moves by one clock period against the start edge, and the index, data and sample values come out shifted by one bit. A tag flag that goes stale or is captured at the wrong time shows as a strobe during a not-ready frame, or as a strobe that is missing when only one tag bit is set. A frame-state machine that does not restart or finish correctly shows as a missing or extra `frame_done` within 257 cycles of the start. It also shows as strobes from an aborted frame, or as a lost second frame when frames run back to back.

// File: rtl/ac_rx_pkg.sv
package ac_rx_pkg;
  localparam int TAG_W      = 16;
  localparam int SLOT_W     = 20;
  localparam int NUM_SLOTS  = 12;
  localparam int FRAME_BITS = TAG_W + NUM_SLOTS * SLOT_W;
  localparam int CNT_W      = $clog2(FRAME_BITS);

  // status reply fields inside slots 1 and 2
  localparam int IDX_W    = 7;
  localparam int IDX_LSB  = 12;
  localparam int STAT_W   = 16;
  localparam int STAT_LSB = 4;

  // tag bit positions
  localparam int TB_READY = 15;
  localparam int TB_ADDR  = 14;
  localparam int TB_DATA  = 13;
  localparam int TB_LEFT  = 12;

  localparam int SMP_CH    = 2;
  localparam int SMP_SLOT0 = 3;

  // frame position of the last bit of slot k (k = 0 is the tag)
  function automatic logic [CNT_W-1:0] slot_last(input int k);
    return CNT_W'(TAG_W + k * SLOT_W - 1);
  endfunction
endpackage

// File: rtl/ac_rx_framer.sv
module ac_rx_framer
  import ac_rx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync,
  output logic             take,
  output logic [CNT_W-1:0] pos,
  output logic             last,
  output logic             start
);
  logic             sync_q;
  logic             active;
  logic [CNT_W-1:0] cnt;

  assign start = sync & ~sync_q;
  assign take  = active;
  assign pos   = cnt;
  assign last  = active && (cnt == CNT_W'(FRAME_BITS - 1));

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 1'b1;
      active <= 1'b0;
      cnt    <= '0;
    end else begin
      sync_q <= sync;
      if (start) begin
        active <= 1'b1;
        cnt    <= '0;
      end else if (last) begin
        active <= 1'b0;
        cnt    <= '0;
      end else if (active) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R8
  restart_chk: assert property (@(negedge clk) disable iff (!rst_n)
    start |=> (take && pos == '0));

  // R1
  idle_hold_chk: assert property (@(negedge clk) disable iff (!rst_n)
    !start |=> !(take && pos == '0));

  // R2
  frame_len_chk: assert property (@(negedge clk) disable iff (!rst_n)
    last |=> (!take || pos == '0));
endmodule

// File: rtl/ac_rx_shifter.sv
module ac_rx_shifter
  import ac_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              din,
  output logic [SLOT_W-1:0] word
);
  logic [SLOT_W-2:0] sh;

  // word includes the bit sampled on the current edge
  assign word = {sh, din};

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n)    sh <= '0;
    else if (take) sh <= word[SLOT_W-2:0];
  end
endmodule

// File: rtl/ac_rx_slot_decode.sv
module ac_rx_slot_decode
  import ac_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [CNT_W-1:0]  pos,
  input  logic              last,
  input  logic [SLOT_W-1:0] word,
  output logic              link_ready,
  output logic              stat_valid,
  output logic [IDX_W-1:0]  stat_index,
  output logic [STAT_W-1:0] stat_data,
  output logic [SMP_CH-1:0] smp_valid,
  output logic [SLOT_W-1:0] smp_data [SMP_CH],
  output logic              frame_done
);
  logic             rdy_q, addr_q, data_q;
  logic [IDX_W-1:0] idx_pend;
  logic             tag_end, s1_end, s2_end, stat_ok;

  assign tag_end = take && (pos == slot_last(0));
  assign s1_end  = take && (pos == slot_last(1));
  assign s2_end  = take && (pos == slot_last(2));
  assign stat_ok = rdy_q & addr_q & data_q;
  assign link_ready = rdy_q;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q  <= 1'b0;
      addr_q <= 1'b0;
      data_q <= 1'b0;
    end else if (tag_end) begin
      rdy_q  <= word[TB_READY];
      addr_q <= word[TB_ADDR];
      data_q <= word[TB_DATA];
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_pend   <= '0;
      stat_valid <= 1'b0;
      stat_index <= '0;
      stat_data  <= '0;
      frame_done <= 1'b0;
    end else begin
      frame_done <= last;
      stat_valid <= s2_end && stat_ok;
      if (s1_end && stat_ok) idx_pend <= word[IDX_LSB +: IDX_W];
      if (s2_end && stat_ok) begin
        stat_index <= idx_pend;
        stat_data  <= word[STAT_LSB +: STAT_W];
      end
    end
  end

  for (genvar ch = 0; ch < SMP_CH; ch++) begin : g_ch
    localparam int TBIT = TB_LEFT - ch;
    logic              en_q, v_q, s_end;
    logic [SLOT_W-1:0] d_q;

    assign s_end = take && (pos == slot_last(SMP_SLOT0 + ch));

    always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_q <= 1'b0;
        v_q  <= 1'b0;
        d_q  <= '0;
      end else begin
        if (tag_end) en_q <= word[TBIT];
        v_q <= s_end && rdy_q && en_q;
        if (s_end && rdy_q && en_q) d_q <= word;
      end
    end

    assign smp_valid[ch] = v_q;
    assign smp_data[ch]  = d_q;

    // R6 R7
    smp_pulse_chk: assert property (@(negedge clk) disable iff (!rst_n)
      v_q |=> !v_q);
  end

  // R4
  ready_gate_chk: assert property (@(negedge clk) disable iff (!rst_n)
    (stat_valid || (|smp_valid)) |-> link_ready);

  // R5
  stat_pulse_chk: assert property (@(negedge clk) disable iff (!rst_n)
    stat_valid |=> !stat_valid);

  // R2
  done_pulse_chk: assert property (@(negedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);
endmodule

// File: rtl/ac_rx_deser.sv
module ac_rx_deser
  import ac_rx_pkg::*;
(
  input  logic              ser_clk,
  input  logic              rst_n,
  input  logic              frm_sync,
  input  logic              ser_in,
  output logic              link_ready,
  output logic              stat_valid,
  output logic [IDX_W-1:0]  stat_index,
  output logic [STAT_W-1:0] stat_data,
  output logic              left_valid,
  output logic [SLOT_W-1:0] left_sample,
  output logic              right_valid,
  output logic [SLOT_W-1:0] right_sample,
  output logic              frame_done
);
  logic              take, last, start;
  logic [CNT_W-1:0]  pos;
  logic [SLOT_W-1:0] word;
  logic [SMP_CH-1:0] smp_valid;
  logic [SLOT_W-1:0] smp_data [SMP_CH];

  ac_rx_framer u_framer (
    .clk(ser_clk), .rst_n(rst_n), .sync(frm_sync),
    .take(take), .pos(pos), .last(last), .start(start)
  );

  ac_rx_shifter u_shift (
    .clk(ser_clk), .rst_n(rst_n), .take(take), .din(ser_in), .word(word)
  );

  ac_rx_slot_decode u_dec (
    .clk(ser_clk), .rst_n(rst_n), .take(take), .pos(pos), .last(last),
    .word(word), .link_ready(link_ready), .stat_valid(stat_valid),
    .stat_index(stat_index), .stat_data(stat_data),
    .smp_valid(smp_valid), .smp_data(smp_data), .frame_done(frame_done)
  );

  assign left_valid   = smp_valid[0];
  assign left_sample  = smp_data[0];
  assign right_valid  = smp_valid[1];
  assign right_sample = smp_data[1];
endmodule

// File: tb/ac_rx_deser_test.sv
module ac_rx_deser_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sync = 1'b1;
  logic        sdata = 1'b0;
  logic        link_ready, stat_valid, left_valid, right_valid, frame_done;
  logic [6:0]  stat_index;
  logic [15:0] stat_data;
  logic [19:0] left_sample, right_sample;

  int checks = 0, errors = 0;
  int cyc = 0, n_stat = 0, n_left = 0, n_right = 0, n_done = 0;
  int t_stat = 0, t_left = 0, t_right = 0, t_done = 0;

  always #4 clk = ~clk;

  ac_rx_deser uut (
    .ser_clk(clk), .rst_n(rst_n), .frm_sync(sync), .ser_in(sdata),
    .link_ready(link_ready), .stat_valid(stat_valid), .stat_index(stat_index),
    .stat_data(stat_data), .left_valid(left_valid), .left_sample(left_sample),
    .right_valid(right_valid), .right_sample(right_sample), .frame_done(frame_done)
  );

  // monitor: outputs change on falling edges, observed on rising edges
  always @(posedge clk) begin
    cyc = cyc + 1;
    if (stat_valid)  begin n_stat++;  t_stat = cyc;  end
    if (left_valid)  begin n_left++;  t_left = cyc;  end
    if (right_valid) begin n_right++; t_right = cyc; end
    if (frame_done)  begin n_done++;  t_done = cyc;  end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [255:0] mk(input logic [15:0] tag, input logic [19:0] s1,
                                      input logic [19:0] s2, input logic [19:0] s3,
                                      input logic [19:0] s4);
    return {tag, s1, s2, s3, s4, 160'h0};
  endfunction

  // lead: raise the strobe one cycle ahead; tail: raise it with the last bit
  task automatic send(input logic [255:0] fr, input int nbits, input bit lead,
                      input bit tail, output int t0);
    t0 = 0;
    if (lead) begin
      @(posedge clk); #1;
      t0 = cyc; sync = 1'b1; sdata = 1'b0;
    end
    for (int j = 0; j < nbits; j++) begin
      @(posedge clk); #1;
      sdata = fr[255 - j];
      sync  = ((j + 1) < 16) || (tail && j == nbits - 1);
    end
  endtask

  task automatic idle(input int n);
    sync = 1'b0; sdata = 1'b0;
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (300) @(posedge clk);
    #1;
    chk("R1 strobe high at reset release starts no frame", n_done, 0);
    chk("R3 link_ready after reset", link_ready, 0);
    chk("R4 no strobes after reset", n_stat + n_left + n_right, 0);
    idle(5);
  endtask

  task automatic t_full;
    int t0, s0, l0, r0, d0;
    s0 = n_stat; l0 = n_left; r0 = n_right; d0 = n_done;
    send(mk(16'hF800, 20'h26000 | 20'h00ABC, 20'hBEEF3, 20'h12345, 20'hABCDE), 256, 1, 0, t0);
    idle(4);
    chk("R5 one status strobe", n_stat - s0, 1);
    chk("R5 status strobe at bit 55", t_stat - t0, 57);
    chk("R5 stat_index slot1[18:12]", stat_index, 7'h26);
    chk("R5 stat_data slot2[19:4]", stat_data, 16'hBEEF);
    chk("R6 left strobe count", n_left - l0, 1);
    chk("R6 left strobe at bit 75", t_left - t0, 77);
    chk("R6 left sample", left_sample, 20'h12345);
    chk("R7 right strobe count", n_right - r0, 1);
    chk("R7 right strobe at bit 95", t_right - t0, 97);
    chk("R7 right sample", right_sample, 20'hABCDE);
    chk("R2 frame_done count", n_done - d0, 1);
    chk("R2 frame_done after bit 255", t_done - t0, 257);
    chk("R3 link_ready set", link_ready, 1);
    idle(50);
    chk("R3 link_ready holds between frames", link_ready, 1);
  endtask

  task automatic t_not_ready;
    int t0, s0, l0, r0, d0;
    s0 = n_stat; l0 = n_left; r0 = n_right; d0 = n_done;
    send(mk(16'h7800, 20'h7F000, 20'hFFFFF, 20'h55555, 20'h66666), 256, 1, 0, t0);
    idle(4);
    chk("R4 no strobes when not ready", (n_stat - s0) + (n_left - l0) + (n_right - r0), 0);
    chk("R4 samples unchanged", left_sample, 20'h12345);
    chk("R4 frame_done still pulses", n_done - d0, 1);
    chk("R3 link_ready cleared by tag", link_ready, 0);
  endtask

  task automatic t_partial_tags;
    int t0, s0, l0, r0;
    s0 = n_stat; l0 = n_left; r0 = n_right;
    send(mk(16'hD000, 20'h11000, 20'h22220, 20'h0F0F1, 20'h99999), 256, 1, 0, t0);
    idle(4);
    chk("R5 no status without tag bit 13", n_stat - s0, 0);
    chk("R6 left with tag bit 12", n_left - l0, 1);
    chk("R6 left value", left_sample, 20'h0F0F1);
    chk("R7 no right without tag bit 11", n_right - r0, 0);
    s0 = n_stat; l0 = n_left; r0 = n_right;
    send(mk(16'hA800, 20'h11000, 20'h22220, 20'h33333, 20'h80001), 256, 1, 0, t0);
    idle(4);
    chk("R5 no status without tag bit 14", n_stat - s0, 0);
    chk("R6 no left without tag bit 12", n_left - l0, 0);
    chk("R7 right with tag bit 11", n_right - r0, 1);
    chk("R7 right value", right_sample, 20'h80001);
  endtask

  task automatic t_abort;
    int t0, s0, l0, d0;
    s0 = n_stat; l0 = n_left; d0 = n_done;
    send(mk(16'hF800, 20'h05000, 20'h1234F, 20'hDEAD1, 20'hDEAD2), 60, 1, 0, t0);
    chk("R8 completed slot strobes before abort", n_stat - s0, 1);
    chk("R8 partial status value", stat_data, 16'h1234);
    send(mk(16'hB000, 20'h0, 20'h0, 20'h00777, 20'h0), 256, 1, 0, t0);
    idle(4);
    chk("R8 aborted frame gives no done", n_done - d0, 1);
    chk("R8 only new frame's left sample", n_left - l0, 1);
    chk("R8 new frame left value", left_sample, 20'h00777);
  endtask

  task automatic t_back_to_back;
    int t0, t1, d0, r0;
    d0 = n_done; r0 = n_right;
    send(mk(16'h8800, 20'h0, 20'h0, 20'h0, 20'h0AAAA), 256, 1, 1, t0);
    send(mk(16'h8800, 20'h0, 20'h0, 20'h0, 20'h05555), 256, 0, 0, t1);
    idle(4);
    chk("R9 both frames complete", n_done - d0, 2);
    chk("R9 both right strobes", n_right - r0, 2);
    chk("R9 second frame aligned", right_sample, 20'h05555);
    chk("R9 second done 256 cycles later", t_done - t0, 513);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog R2 actual hung expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_full();
    t_not_ready();
    t_partial_tags();
    t_abort();
    t_back_to_back();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule